// File: doc/BRIEF.md
# Prescaled Match Timer with PWM

This block is a free-running counter/timer for a peripheral subsystem. A prescale counter divides the input clock. Each time it wraps, the main count advances by one. Four compare values watch the main count. When the count reaches a compare value, that channel can do any mix of three things: raise an interrupt flag, restart the count, or halt the timer by clearing its run bit.

The three lower channels can also produce single-edge PWM. In that mode the fourth compare value sets the period. Software programs the block through a plain write port and reads it back through a read port with one clock of latency. The interrupt flags are cleared by writing one to their bit.

Top module: `pwm_match_timer`

## Requirements
- R1: While the run bit (control bit 0) is set, the prescale counter steps every clock and wraps after reaching the prescale value P. The main count therefore advances once every P+1 clocks, on the edge where the prescale counter wraps.
- R2: When a channel has restart enabled (bit 1 of its field) and the count equals its compare value, the count keeps that value for a full prescaled period. It goes to 0 on the next advance.
- R3: When a channel has its interrupt enable set (bit 0 of its field), its flag is set on the clock edge after the one on which the count took the compare value.
- R4: When a channel has halt enabled (bit 2 of its field), the run bit reads 0 from the clock edge after the count reaches the compare value. The count then stays frozen.
- R5: Writing 1 to a bit of the flag register (address 3) clears that flag. A new match on the same edge wins, and the flag stays set.
- R6: While control bit 1 is set, the prescale counter (address 10) and the count (address 2) are held at 0. Counting resumes from 0 once the bit is cleared.
- R7: When any bit of the PWM select register (address 9, bit i for channel i, i = 0..2) is set, compare value 3 sets the period and the count restarts after it. A selected output is low from the start of each period and high from the count equal to its compare value. The output is registered, so it lags the count by one clock.
- R8: A selected PWM output with compare value 0 stays high for the whole period. One whose compare value equals the period value stays low.
- R9: An output not in PWM mode shows, one clock later, whether the count equals that channel's compare value.
- R10: When several channels match at once, any restart or halt among them takes effect.
- R11: Register map. Control is at address 0, with bit 0 run and bit 1 hold. Prescale is at 1, count at 2, flags at 3, and compare values 0..3 at addresses 4..7. The channel control field is at 8, with 3 bits per channel and channel i at bits 3i+2..3i. PWM select is at 9 and the prescale counter at 10. A read requested on one edge returns its data with rd_valid after that edge. Reset clears every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data holds the result of the previous read strobe |
| irq_flags | output | 4 | Per-channel interrupt flags |
| match_out | output | 4 | Per-channel PWM or equality output, registered |

## Verification
The assertions assume that software does not rewrite a compare value or the channel control field during the clock that a flag is being set. They also assume that the control register is not written while a halt is taking effect, because the halt assertion excludes cycles with a control write. The stimulus always parks the timer with the hold bit before it changes any setting, and then restarts it with a single control write. As a result, every match and halt happens while the configuration is stable, and the flag-clear race is exercised only through the intended same-edge collision.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int A_CTRL  = 0;
  localparam int A_PRE   = 1;
  localparam int A_CNT   = 2;
  localparam int A_FLAG  = 3;
  localparam int MT_BASE = 4;
  localparam int MCTL_W  = 3;
  localparam int B_IRQ   = 0;
  localparam int B_RST   = 1;
  localparam int B_STOP  = 2;
  localparam int C_RUN   = 0;
  localparam int C_HOLD  = 1;
endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         hold,
  input  logic [W-1:0] limit,
  output logic [W-1:0] pcount,
  output logic         tick
);
  assign tick = run && !hold && (pcount >= limit);

  always_ff @(posedge clk) begin
    if (rst || hold) pcount <= '0;
    else if (run)    pcount <= tick ? '0 : pcount + 1'b1;
  end

  // R1: a wrap always returns the divider to zero
  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> pcount == '0);
endmodule

// File: rtl/pmt_match_chan.sv
module pmt_match_chan #(
  parameter int W           = 32,
  parameter bit PWM_CAPABLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] count,
  input  logic [W-1:0] mval,
  input  logic [W-1:0] cyc_len,
  input  logic         pwm_sel,
  output logic         hit,
  output logic         pin
);
  logic pwm_on;
  logic level;

  assign hit    = (count == mval);
  assign pwm_on = PWM_CAPABLE && pwm_sel;
  assign level  = pwm_on ? ((mval < cyc_len) && (count >= mval)) : hit;

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= level;
  end

  // R8: compare value equal to the period never drives the output high
  assert_flat_low_R8: assert property (@(posedge clk) disable iff (rst)
    (pwm_on && mval == cyc_len) |=> !pin);
  // R8: compare value zero keeps the output high
  assert_flat_high_R8: assert property (@(posedge clk) disable iff (rst)
    (pwm_on && mval == '0) |=> pin);
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
  import pmt_pkg::*;
#(
  parameter int CW   = 32,
  parameter int NCH  = 4,
  parameter int NPWM = 3,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data,
  output logic          rd_valid,
  output logic [NCH-1:0] irq_flags,
  output logic [NCH-1:0] match_out
);
  localparam int MCW      = MCTL_W * NCH;
  localparam int A_MCTL   = MT_BASE + NCH;
  localparam int A_PWMSEL = A_MCTL + 1;
  localparam int A_PCNT   = A_MCTL + 2;
  localparam int CH_LAST  = NCH - 1;

  logic            run_q, hold_q, tick_q;
  logic [CW-1:0]   pre_q, tc_q, pcount;
  logic [CW-1:0]   mt_q [NCH];
  logic [MCW-1:0]  mctl_q;
  logic [NPWM-1:0] pwmsel_q;
  logic [NCH-1:0]  flags_q;
  logic [NCH-1:0]  hit, evt, irq_en, rst_en, stop_en, sel_ext;
  logic            tick, pwm_mode, restart, halt;
  logic            wr_ctrl, wr_flag;
  logic [CW-1:0]   rd_mux;

  assign wr_ctrl = wr_en && (wr_addr == AW'(A_CTRL));
  assign wr_flag = wr_en && (wr_addr == AW'(A_FLAG));

  pmt_prescaler #(.W(CW)) u_pre (
    .clk(clk), .rst(rst), .run(run_q), .hold(hold_q),
    .limit(pre_q), .pcount(pcount), .tick(tick)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_ch
      if (gi < NPWM) begin : g_sel
        assign sel_ext[gi] = pwmsel_q[gi];
      end else begin : g_nosel
        assign sel_ext[gi] = 1'b0;
      end
      assign irq_en[gi]  = mctl_q[MCTL_W*gi + B_IRQ];
      assign rst_en[gi]  = mctl_q[MCTL_W*gi + B_RST];
      assign stop_en[gi] = mctl_q[MCTL_W*gi + B_STOP];
      assign evt[gi]     = tick_q && hit[gi];

      pmt_match_chan #(.W(CW), .PWM_CAPABLE(gi < NPWM)) u_ch (
        .clk(clk), .rst(rst), .count(tc_q), .mval(mt_q[gi]),
        .cyc_len(mt_q[CH_LAST]), .pwm_sel(sel_ext[gi]),
        .hit(hit[gi]), .pin(match_out[gi])
      );

      // R3: a flag only rises after a fresh arrival at an enabled compare value
      assert_flag_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q[gi]) |-> $past(tick_q && tc_q == mt_q[gi] && irq_en[gi]));
      // R5: a set request is never lost to a simultaneous clear
      assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (evt[gi] && irq_en[gi]) |=> flags_q[gi]);
    end
  endgenerate

  assign pwm_mode = |pwmsel_q;
  assign restart  = |(hit & rst_en) || (pwm_mode && hit[CH_LAST]);
  assign halt     = |(evt & stop_en);

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q    <= '0;
      mctl_q   <= '0;
      pwmsel_q <= '0;
      for (int i = 0; i < NCH; i++) mt_q[i] <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_PRE))    pre_q    <= wr_data;
      if (wr_addr == AW'(A_MCTL))   mctl_q   <= wr_data[MCW-1:0];
      if (wr_addr == AW'(A_PWMSEL)) pwmsel_q <= wr_data[NPWM-1:0];
      for (int i = 0; i < NCH; i++)
        if (wr_addr == AW'(MT_BASE + i)) mt_q[i] <= wr_data;
    end
  end

  // control bits: a halt overrides a concurrent write of the run bit
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= wr_data[C_RUN];
        hold_q <= wr_data[C_HOLD];
      end
      if (halt) run_q <= 1'b0;
    end
  end

  // main count: advances on a divider wrap, restarts at the end of the held period
  always_ff @(posedge clk) begin
    if (rst || hold_q) begin
      tc_q   <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick;
      if (tick) tc_q <= restart ? '0 : tc_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~(wr_flag ? wr_data[NCH-1:0] : '0)) | (evt & irq_en);
  end
  assign irq_flags = flags_q;

  always_comb begin
    rd_mux = '0;
    if (rd_addr == AW'(A_CTRL))   rd_mux = CW'({hold_q, run_q});
    if (rd_addr == AW'(A_PRE))    rd_mux = pre_q;
    if (rd_addr == AW'(A_CNT))    rd_mux = tc_q;
    if (rd_addr == AW'(A_FLAG))   rd_mux = CW'(flags_q);
    if (rd_addr == AW'(A_MCTL))   rd_mux = CW'(mctl_q);
    if (rd_addr == AW'(A_PWMSEL)) rd_mux = CW'(pwmsel_q);
    if (rd_addr == AW'(A_PCNT))   rd_mux = pcount;
    for (int i = 0; i < NCH; i++)
      if (rd_addr == AW'(MT_BASE + i)) rd_mux = mt_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  // R2/R1: between divider wraps the count does not move
  assert_count_held_R2: assert property (@(posedge clk) disable iff (rst)
    (run_q && !hold_q && !tick) |=> tc_q == $past(tc_q));
  // R4: once halted and untouched, the count stays frozen
  assert_stop_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !hold_q && !wr_ctrl) |=> tc_q == $past(tc_q));
  // R4: a halting match clears the run bit on the next edge
  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (rst)
    halt |=> !run_q);
  // R6: hold forces both counters to zero
  assert_hold_zero_R6: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> (tc_q == '0 && pcount == '0));
endmodule

// File: tb/pwm_match_timer_bench.sv
module pwm_match_timer_bench;
  localparam int AD_CTRL = 0, AD_PRE = 1, AD_CNT = 2, AD_FLAG = 3;
  localparam int AD_MT0 = 4, AD_MT1 = 5, AD_MT2 = 6, AD_MT3 = 7;
  localparam int AD_MCTL = 8, AD_PSEL = 9, AD_PCNT = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [3:0]  irq_flags, match_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] exp_v;
  string       tag_v;

  always #10 clk = ~clk;

  pwm_match_timer u_pwm_match_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq_flags(irq_flags), .match_out(match_out)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: issue a read and push the expected result for the monitor
  task automatic rd_expect(input int a, input logic [31:0] e, input string tag);
    rd_en = 1'b1; rd_addr = 4'(a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: compare each returned read against the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected read act=%0h exp=none", rd_data);
      end else begin
        exp_v = exp_q.pop_front();
        tag_v = tag_q.pop_front();
        if (rd_data !== exp_v) begin
          fails++;
          $display("FAIL %s act=%0h exp=%0h", tag_v, rd_data, exp_v);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(32'(irq_flags), 32'h0, "R11 reset flags");
    chk(32'(match_out), 32'hF, "R9 reset equality outputs");
    rd_expect(AD_CTRL, 32'h0, "R11 reset control");
    rd_expect(AD_CNT, 32'h0, "R11 reset count");

    // prescale 2, channel 0 at 6 with interrupt and restart
    wr(AD_PRE, 2);
    wr(AD_MT0, 6);
    wr(AD_MCTL, 32'h3);
    rd_expect(AD_PRE, 32'd2, "R11 prescale readback");
    wr(AD_CTRL, 1);                       // edge E0
    repeat (2) @(negedge clk);            // after E2
    rd_expect(AD_CNT, 32'd0, "R1 count before first wrap");
    rd_expect(AD_CNT, 32'd1, "R1 count after third clock");
    repeat (14) @(negedge clk);           // after E18, count = 6
    chk(32'(irq_flags[0]), 32'd0, "R3 flag not on arrival edge");
    chk(32'(match_out[0]), 32'd0, "R9 output lags count");
    @(negedge clk);                       // after E19
    chk(32'(irq_flags[0]), 32'd1, "R3 flag one clock later");
    chk(32'(match_out[0]), 32'd1, "R9 equality output");
    rd_expect(AD_CNT, 32'd6, "R2 held value early");
    rd_expect(AD_CNT, 32'd6, "R2 held value full period");
    rd_expect(AD_CNT, 32'd0, "R2 restart after period");
    wr(AD_FLAG, 1);                       // E23
    chk(32'(irq_flags[0]), 32'd0, "R5 write one clears");
    repeat (16) @(negedge clk);           // after E39
    wr(AD_FLAG, 1);                       // E40, match event on same edge
    chk(32'(irq_flags[0]), 32'd1, "R5 new match beats clear");

    // halt on channel 1
    wr(AD_CTRL, 2);
    wr(AD_FLAG, 15);
    wr(AD_MCTL, 32'h28);
    wr(AD_MT1, 6);
    wr(AD_CTRL, 1);                       // E0
    repeat (18) @(negedge clk);           // after E18
    chk(32'(irq_flags[1]), 32'd0, "R4 no flag on arrival edge");
    @(negedge clk);                       // after E19
    chk(32'(irq_flags[1]), 32'd1, "R4 flag with halt");
    rd_expect(AD_CTRL, 32'd0, "R4 run bit cleared");
    rd_expect(AD_CNT, 32'd6, "R4 count at halt");
    repeat (5) @(negedge clk);
    rd_expect(AD_CNT, 32'd6, "R4 count frozen");

    // PWM: period 10, ch0 at 4, ch1 at 0, ch2 equal to period
    wr(AD_CTRL, 2);
    wr(AD_FLAG, 15);
    wr(AD_MCTL, 0);
    wr(AD_PRE, 0);
    wr(AD_MT0, 4);
    wr(AD_MT1, 0);
    wr(AD_MT2, 10);
    wr(AD_MT3, 10);
    wr(AD_PSEL, 7);
    chk(32'(match_out[2:0]), 32'h2, "R8 idle PWM levels");
    wr(AD_CTRL, 1);                       // E0
    repeat (4) @(negedge clk);            // after E4
    chk(32'(match_out[0]), 32'd0, "R7 low before compare");
    @(negedge clk);                       // after E5
    chk(32'(match_out[0]), 32'd1, "R7 high from compare");
    repeat (6) @(negedge clk);            // after E11
    chk(32'(match_out[0]), 32'd1, "R7 high at period end");
    chk(32'(match_out[2]), 32'd0, "R8 equal to period stays low");
    @(negedge clk);                       // after E12
    chk(32'(match_out[0]), 32'd0, "R7 low at new period");
    chk(32'(match_out[1]), 32'd1, "R8 zero compare stays high");
    chk(32'(match_out[2]), 32'd0, "R8 no edge in period");
    rd_expect(AD_CNT, 32'd1, "R7 count restarted after period");

    // hold
    wr(AD_CTRL, 3);
    repeat (3) @(negedge clk);
    rd_expect(AD_CNT, 32'd0, "R6 count held at zero");
    rd_expect(AD_PCNT, 32'd0, "R6 prescale counter held at zero");
    wr(AD_CTRL, 1);                       // F0
    repeat (3) @(negedge clk);            // after F3
    rd_expect(AD_CNT, 32'd3, "R6 resumes from zero");

    // simultaneous halt (ch1) and restart (ch2) at 3
    wr(AD_CTRL, 2);
    wr(AD_PSEL, 0);
    wr(AD_FLAG, 15);
    wr(AD_MT1, 3);
    wr(AD_MT2, 3);
    wr(AD_MCTL, 32'hA8);
    rd_expect(AD_MCTL, 32'hA8, "R11 field readback");
    wr(AD_CTRL, 1);                       // E0
    repeat (4) @(negedge clk);            // after E4
    chk(32'(irq_flags), 32'h2, "R10 only channel 1 flag");
    rd_expect(AD_CTRL, 32'd0, "R10 halt applied");
    rd_expect(AD_CNT, 32'd0, "R10 restart applied");
    rd_expect(AD_CNT, 32'd0, "R10 stays halted");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R11 missing reads act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule